// File: doc/BRIEF.md
# Segment-Aware Direct-Mapped Instruction Cache

This block sits between the instruction fetch port of a 32-bit processor and a plain word-wide memory read bus. It holds up to 1024 instruction words in 256 lines of four words each. The line is picked by the low address bits alone, so the cache is direct-mapped.

Whether a fetch may use the cache depends on the top three address bits. Any other global enable has no effect on this choice.

- **Cacheable:** the two low segments, where bit 31 is 0 or bits [31:29] are 100.
- **Uncached:** bits [31:29] of 101 select a segment that never hits and never allocates.
- **No code:** bits [31:30] of 11 select a segment that is also served uncached.

The tag is taken from the physical address, which is the low 29 bits. A word reached through either cacheable segment therefore lands in the same line.

**Fetch handshake.** One fetch is in flight at a time. A request is taken on a cycle with `fetch_valid` and `fetch_ready` both high. `fetch_ready` stays low until the response has been taken.

**Response back-pressure.** The response is presented with `resp_valid`. It holds, with `resp_data` unchanged, until the consumer raises `resp_ready`.

**Bus handshake.** The memory side presents `bus_rd_valid` and `bus_rd_addr`. These stay unchanged until `bus_rd_ready` is high. In that cycle `bus_rd_data` carries the word.

**Miss and invalidate.** A cacheable miss fetches the whole line, lowest word first. The line becomes valid only after its last word has arrived. `inv_all` drops every line at once.

Top module: `icache_seg`

## Requirements
- R1: After reset `fetch_ready` is 1, `resp_valid` is 0 and `bus_rd_valid` is 0. Every line is invalid, so the first cacheable fetch misses.
- R2: A cacheable miss issues exactly 4 bus reads, at line base +0, +4, +8 and +12 in that order. The response is the word at the fetch address (bits [3:2] select it).
- R3: A cacheable fetch whose line is valid with a matching tag makes no bus read. It raises `resp_valid` in the cycle after acceptance.
- R4: A fetch with address bits [31:29] = 101 makes exactly one bus read of that word and returns it. It allocates nothing: a repeat fetch reads the bus again, and so does a later cacheable fetch of the same physical word.
- R5: A fetch with address bits [31:30] = 11 is served like R4: one bus read each time, and no allocation.
- R6: Cacheable addresses that differ only in bits [31:29] hit the same line.
- R7: Two cacheable addresses with equal bits [11:4] and different bits [28:12] evict each other.
- R8: `bus_rd_addr` always has bits [31:29] = 000. Its bits [28:2] are physical address bits, and bits [1:0] are 00.
- R9: A one-cycle pulse on `inv_all` makes every previously filled line miss.
- R10: When `inv_all` is pulsed during a line fill, the fill still returns the correct word, but the line is left invalid.
- R11: While `resp_valid` is 1 and `resp_ready` is 0, the response and its data hold steady, and `fetch_ready` stays 0.
- R12: While `bus_rd_valid` is 1 and `bus_rd_ready` is 0, the request and its address hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_all | input | 1 | Invalidate every line |
| fetch_valid | input | 1 | Fetch request present |
| fetch_ready | output | 1 | Fetch request can be taken |
| fetch_addr | input | 32 | Fetch byte address (word aligned) |
| resp_valid | output | 1 | Instruction word available |
| resp_ready | input | 1 | Consumer takes the word |
| resp_data | output | 32 | Instruction word |
| bus_rd_valid | output | 1 | Bus read request |
| bus_rd_ready | input | 1 | Bus returns the word this cycle |
| bus_rd_addr | output | 32 | Physical word address of the read |
| bus_rd_data | input | 32 | Word returned by the bus |

## Verification
The bench counts bus reads per fetch, with a bus that stalls two cycles out of three. This catches a cache that hits on uncached segments or allocates from them: a repeat fetch there would make zero reads instead of one.

Alias fetches through the two cacheable segments expose a tag that keeps segment bits, since that design would miss where a hit is due. A conflicting pair with equal index bits exposes a tag that is too narrow, which would give a false hit returning the wrong word.

An invalidate pulse landing in the middle of a fill shows whether the valid bit is wrongly set at the end of that fill. A response held under back-pressure shows any data drift or early acceptance of a new fetch.

// File: rtl/icache_seg_pkg.sv
package icache_seg_pkg;
  localparam int PHYS_W = 29;

  typedef enum logic [1:0] {
    SEG_CACHED,
    SEG_UNCACHED,
    SEG_NOCODE
  } seg_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_UNC,
    ST_RESP
  } st_e;
endpackage

// File: rtl/icache_seg_decode.sv
module icache_seg_decode
  import icache_seg_pkg::*;
(
  input  logic [31:0] addr,
  output seg_e        seg,
  output logic        cacheable
);
  always_comb begin
    unique case (addr[31:29])
      3'b101:         seg = SEG_UNCACHED;
      3'b110, 3'b111: seg = SEG_NOCODE;
      default:        seg = SEG_CACHED;
    endcase
    cacheable = (seg == SEG_CACHED);
  end
endmodule

// File: rtl/icache_seg_store.sv
module icache_seg_store #(
  parameter int NUM_LINES  = 256,
  parameter int LINE_WORDS = 4,
  parameter int TAG_W      = 17
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr_all,
  input  logic [$clog2(NUM_LINES)-1:0]  rd_idx,
  input  logic [$clog2(LINE_WORDS)-1:0] rd_word,
  input  logic [TAG_W-1:0]              rd_tag,
  output logic                          hit,
  output logic [31:0]                   rd_data,
  input  logic                          wr_en,
  input  logic [$clog2(NUM_LINES)-1:0]  wr_idx,
  input  logic [$clog2(LINE_WORDS)-1:0] wr_word,
  input  logic [31:0]                   wr_data,
  input  logic                          set_en,
  input  logic [TAG_W-1:0]              set_tag
);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int WORDS = NUM_LINES * LINE_WORDS;

  logic [NUM_LINES-1:0] valid_q;
  logic [TAG_W-1:0]     tag_q  [NUM_LINES];
  logic [31:0]          word_q [WORDS];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n || clr_all) begin
        valid_q[g] <= 1'b0;
      end else if (set_en && wr_idx == IDX_W'(g)) begin
        valid_q[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (set_en) tag_q[wr_idx] <= set_tag;
    if (wr_en)  word_q[{wr_idx, wr_word}] <= wr_data;
  end

  always_comb begin
    hit     = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    rd_data = word_q[{rd_idx, rd_word}];
  end

  logic unused_off;
  assign unused_off = ^OFF_W;
endmodule

// File: rtl/icache_seg.sv
module icache_seg
  import icache_seg_pkg::*;
#(
  parameter int NUM_LINES  = 256,
  parameter int LINE_WORDS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inv_all,
  input  logic        fetch_valid,
  output logic        fetch_ready,
  input  logic [31:0] fetch_addr,
  output logic        resp_valid,
  input  logic        resp_ready,
  output logic [31:0] resp_data,
  output logic        bus_rd_valid,
  input  logic        bus_rd_ready,
  output logic [31:0] bus_rd_addr,
  input  logic [31:0] bus_rd_data
);
  localparam int OFF_W   = $clog2(LINE_WORDS);
  localparam int IDX_W   = $clog2(NUM_LINES);
  localparam int IDX_LSB = 2 + OFF_W;
  localparam int TAG_LSB = IDX_LSB + IDX_W;
  localparam int TAG_W   = PHYS_W - TAG_LSB;

  st_e               st_q;
  logic [PHYS_W-1:0] req_q;
  logic [OFF_W-1:0]  cnt_q;
  logic              kill_q;
  logic [31:0]       data_q;

  seg_e        seg;
  logic        cacheable;
  logic        hit;
  logic [31:0] rd_data;
  logic        accept, beat, last, wr_en, set_en;

  icache_seg_decode u_decode (
    .addr      (fetch_addr),
    .seg       (seg),
    .cacheable (cacheable)
  );

  icache_seg_store #(
    .NUM_LINES  (NUM_LINES),
    .LINE_WORDS (LINE_WORDS),
    .TAG_W      (TAG_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_all (inv_all),
    .rd_idx  (fetch_addr[IDX_LSB +: IDX_W]),
    .rd_word (fetch_addr[2 +: OFF_W]),
    .rd_tag  (fetch_addr[TAG_LSB +: TAG_W]),
    .hit     (hit),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_idx  (req_q[IDX_LSB +: IDX_W]),
    .wr_word (cnt_q),
    .wr_data (bus_rd_data),
    .set_en  (set_en),
    .set_tag (req_q[TAG_LSB +: TAG_W])
  );

  always_comb begin
    fetch_ready  = (st_q == ST_IDLE);
    accept       = fetch_valid && fetch_ready;
    resp_valid   = (st_q == ST_RESP);
    resp_data    = data_q;
    bus_rd_valid = (st_q == ST_FILL) || (st_q == ST_UNC);
    if (st_q == ST_FILL)
      bus_rd_addr = {3'b000, req_q[PHYS_W-1:IDX_LSB], cnt_q, 2'b00};
    else
      bus_rd_addr = {3'b000, req_q[PHYS_W-1:2], 2'b00};
    beat   = bus_rd_valid && bus_rd_ready;
    last   = (cnt_q == OFF_W'(LINE_WORDS - 1));
    wr_en  = (st_q == ST_FILL) && beat;
    set_en = wr_en && last && !kill_q && !inv_all;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      req_q  <= '0;
      cnt_q  <= '0;
      kill_q <= 1'b0;
      data_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          req_q  <= fetch_addr[PHYS_W-1:0];
          cnt_q  <= '0;
          kill_q <= 1'b0;
          if (cacheable && hit) begin
            data_q <= rd_data;
            st_q   <= ST_RESP;
          end else if (cacheable) begin
            st_q <= ST_FILL;
          end else begin
            st_q <= ST_UNC;
          end
        end
        ST_FILL: begin
          if (inv_all) kill_q <= 1'b1;
          if (beat) begin
            if (cnt_q == req_q[2 +: OFF_W]) data_q <= bus_rd_data;
            cnt_q <= cnt_q + 1'b1;
            if (last) st_q <= ST_RESP;
          end
        end
        ST_UNC: if (beat) begin
          data_q <= bus_rd_data;
          st_q   <= ST_RESP;
        end
        ST_RESP: if (resp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  logic unused_seg;
  assign unused_seg = ^seg;
endmodule

// File: rtl/icache_seg_chk.sv
module icache_seg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        inv_all,
  input logic        fetch_valid,
  input logic        fetch_ready,
  input logic [31:0] fetch_addr,
  input logic        resp_valid,
  input logic        resp_ready,
  input logic [31:0] resp_data,
  input logic        bus_rd_valid,
  input logic        bus_rd_ready,
  input logic [31:0] bus_rd_addr,
  input logic [31:0] bus_rd_data
);
  // R11
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_data));

  // R11
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !fetch_ready);

  // R12
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_valid && !bus_rd_ready |=> bus_rd_valid && $stable(bus_rd_addr));

  // R8
  phys_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_valid |-> bus_rd_addr[31:29] == 3'b000 && bus_rd_addr[1:0] == 2'b00);

  // R4
  uncached_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_ready && fetch_addr[31:29] == 3'b101 |=>
      bus_rd_valid && bus_rd_addr == {3'b000, $past(fetch_addr[28:2]), 2'b00});

  logic unused_chk;
  assign unused_chk = ^{inv_all, bus_rd_data};
endmodule

bind icache_seg icache_seg_chk u_chk (.*);

// File: tb/tb_icache_seg.sv
module tb_icache_seg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inv_all = 1'b0;
  logic        fetch_valid = 1'b0;
  logic        fetch_ready;
  logic [31:0] fetch_addr = '0;
  logic        resp_valid;
  logic        resp_ready = 1'b1;
  logic [31:0] resp_data;
  logic        bus_rd_valid;
  logic        bus_rd_ready = 1'b1;
  logic [31:0] bus_rd_addr;
  logic [31:0] bus_rd_data = '0;

  int checks = 0;
  int fails  = 0;
  int nrd    = 0;
  int tick   = 0;
  logic stall_en = 1'b1;
  logic [31:0] rd_log [16];

  always #10 clk = ~clk;

  icache_seg dut (.*);

  function automatic logic [31:0] memword(input logic [31:0] a);
    return ({3'b000, a[28:0]} * 32'h9E3779B1) ^ 32'hC001D00D;
  endfunction

  // bus model: drives away from the active edge
  always @(negedge clk) begin
    tick++;
    bus_rd_ready = stall_en ? (tick % 3 == 2) : 1'b1;
    bus_rd_data  = memword(bus_rd_addr);
  end

  always @(posedge clk) begin
    if (rst_n && bus_rd_valid && bus_rd_ready) begin
      rd_log[nrd % 16] <= bus_rd_addr;
      nrd <= nrd + 1;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [31:0] a, input int hold,
                          output logic [31:0] data, output int reads,
                          output int lat, output logic hold_ok);
    int r0;
    r0 = nrd;
    hold_ok = 1'b1;
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_addr  = a;
    resp_ready  = (hold == 0);
    while (!fetch_ready) @(negedge clk);
    @(negedge clk);
    fetch_valid = 1'b0;
    lat = 1;
    while (!resp_valid) begin
      @(negedge clk);
      lat++;
    end
    data = resp_data;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (!resp_valid || resp_data != data || fetch_ready) hold_ok = 1'b0;
    end
    resp_ready = 1'b1;
    @(negedge clk);
    reads = nrd - r0;
  endtask

  // {requirement number, address, expected bus reads}
  localparam logic [71:0] VEC [14] = '{
    {8'd2, 32'h8000_1234, 32'd4},  // R2 cold miss
    {8'd3, 32'h8000_1234, 32'd0},  // R3 hit
    {8'd6, 32'h0000_1238, 32'd0},  // R6 alias through low segment
    {8'd7, 32'h800F_1234, 32'd4},  // R7 conflict evicts
    {8'd7, 32'h8000_1234, 32'd4},  // R7 evicted back
    {8'd4, 32'hA000_1234, 32'd1},  // R4 uncached
    {8'd4, 32'hA000_1234, 32'd1},  // R4 no allocation
    {8'd4, 32'hA000_5000, 32'd1},  // R4 uncached first
    {8'd4, 32'h8000_5000, 32'd4},  // R4 cached view still misses
    {8'd5, 32'hC000_2000, 32'd1},  // R5 no-code segment
    {8'd5, 32'hC000_2000, 32'd1},  // R5 again, no allocation
    {8'd2, 32'h8000_200C, 32'd4},  // R2 last word in line
    {8'd3, 32'h8000_2000, 32'd0},  // R3 first word hits
    {8'd6, 32'h0000_2008, 32'd0}   // R6 alias hit
  };

  initial begin
    logic [31:0] d;
    int rd, lat;
    logic hok;

    // R1 reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fetch_ready == 1'b1, "R1 fetch_ready", 32'(fetch_ready), 32'd1);
    chk(resp_valid == 1'b0, "R1 resp_valid", 32'(resp_valid), 32'd0);
    chk(bus_rd_valid == 1'b0, "R1 bus_rd_valid", 32'(bus_rd_valid), 32'd0);

    foreach (VEC[i]) begin
      logic [31:0] a;
      int exp_rd;
      int start;
      string tag;
      a      = VEC[i][63:32];
      exp_rd = int'(VEC[i][31:0]);
      tag    = $sformatf("R%0d vec%0d", VEC[i][71:64], i);
      start  = nrd;
      do_fetch(a, 0, d, rd, lat, hok);
      chk(d == memword(a), {tag, " data"}, d, memword(a));
      chk(rd == exp_rd, {tag, " bus reads"}, 32'(rd), 32'(exp_rd));
      if (exp_rd == 0) chk(lat == 1, {tag, " hit latency"}, 32'(lat), 32'd1);
      if (exp_rd == 4) begin
        for (int k = 0; k < 4; k++) begin
          logic [31:0] ea;
          ea = {3'b000, a[28:4], 4'b0000} + 32'(4 * k);
          // R2 ordering, R8 physical address
          chk(rd_log[(start + k) % 16] == ea, "R2 R8 fill address",
              rd_log[(start + k) % 16], ea);
        end
      end
      if (exp_rd == 1) begin
        logic [31:0] ea;
        ea = {3'b000, a[28:2], 2'b00};
        chk(rd_log[start % 16] == ea, "R8 uncached address",
            rd_log[start % 16], ea);
      end
    end

    // R9 invalidate all
    @(negedge clk); inv_all = 1'b1;
    @(negedge clk); inv_all = 1'b0;
    do_fetch(32'h8000_2000, 0, d, rd, lat, hok);
    chk(rd == 4, "R9 refill after invalidate", 32'(rd), 32'd4);
    do_fetch(32'h8000_1234, 0, d, rd, lat, hok);
    chk(rd == 4, "R9 other line invalid", 32'(rd), 32'd4);

    // R10 invalidate during fill
    begin
      int r0;
      r0 = nrd;
      fork
        do_fetch(32'h8000_3008, 0, d, rd, lat, hok);
        begin
          wait (nrd == r0 + 1);
          @(negedge clk); inv_all = 1'b1;
          @(negedge clk); inv_all = 1'b0;
        end
      join
    end
    chk(d == memword(32'h8000_3008), "R10 data during killed fill", d,
        memword(32'h8000_3008));
    do_fetch(32'h8000_3008, 0, d, rd, lat, hok);
    chk(rd == 4, "R10 line left invalid", 32'(rd), 32'd4);

    // R11 response back-pressure (line now valid: hit)
    do_fetch(32'h8000_3008, 4, d, rd, lat, hok);
    chk(hok == 1'b1, "R11 hold under back-pressure", 32'(hok), 32'd1);
    chk(d == memword(32'h8000_3008), "R11 held data", d, memword(32'h8000_3008));
    // R12 stalled bus keeps request
    do_fetch(32'hA000_7770, 3, d, rd, lat, hok);
    chk(hok == 1'b1 && d == memword(32'hA000_7770), "R12 R11 uncached held",
        d, memword(32'hA000_7770));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule